// File: doc/BRIEF.md
# In-Flight Address Conflict Checker

This block decides whether a new request may take ownership of a command set. A request carries a short list of target addresses. Before it is allowed to claim a set, every stored command that is still pending in a claimed set is compared with all of the request's addresses. If any of them are equal, the request is refused with a busy result, because two commands to the same target must never be outstanding at once. If nothing collides, the block grants the lowest-numbered free set inside the request's group. The group is a contiguous window of set indices.

The block owns the claimed-set bitmap. A grant marks its set as claimed on the same edge that the result is reported. An external release pulse frees a set again once the owner of that set has finished. The scan walks one stored command slot per clock. It goes set by set across the group and slot by slot inside each set, and it stops early on the first collision. Queuing and retrying a refused request are left to the caller.

Top module: `conflict_claim`

## Requirements
- R1: After an asynchronous reset, no set is claimed (`in_use_o` is zero) and `done_o`, `busy_o` and `grant_o` are low.
- R2: A start sampled in idle with a nonzero group count begins a scan over sets `grp_base_i` up to `grp_base_i + grp_cnt_i - 1`, slots 0 to CMDS-1 within each set, evaluating one slot per clock. Slot n of that order (counted from 0) is evaluated in the cycle that ends with the (n+1)-th rising edge after the start edge. With no collision, the result appears after edge `grp_cnt_i * CMDS`.
- R3: A stored slot takes part in the comparison only if its set is claimed and its enable bit (`slot_en_i[set*CMDS + slot]`) is 1. Address `slot_addr_i` entry `set*CMDS + slot` belongs to that slot.
- R4: Only request entries 0 to `req_cnt_i - 1` are compared, so entries at or beyond the count have no effect on the result.
- R5: When an evaluated slot's address equals a valid request address, `done_o` and `busy_o` pulse on the next edge, no set is granted, and the scan ends.
- R6: When the scan ends without a collision, the lowest-index unclaimed set in the group is granted. `done_o` and `grant_o` pulse, `grant_idx_o` gives the set, and its `in_use_o` bit becomes 1 on that same edge.
- R7: When the scan ends without a collision and every set of the group is claimed, `done_o` and `busy_o` pulse and nothing is granted.
- R8: A start with `grp_cnt_i` equal to zero produces `done_o` and `busy_o` on the very edge that samples the start.
- R9: A start asserted while a scan is running is ignored. It neither restarts nor ends the scan.
- R10: A 1 on `release_i[k]` clears claimed bit k on the next edge. If the same set is granted on that edge, the grant wins and the bit stays 1.
- R11: `busy_o` and `grant_o` are single-cycle pulses that appear only with `done_o`, and exactly one of them accompanies each `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request start, sampled while idle |
| req_addr_i | input | REQ_MAX*ADDR_W | Request addresses, entry j at bits j*ADDR_W |
| req_cnt_i | input | clog2(REQ_MAX+1) | Number of valid request addresses |
| grp_base_i | input | clog2(NUM_SETS) | First set index of the group |
| grp_cnt_i | input | clog2(NUM_SETS+1) | Number of sets in the group |
| slot_en_i | input | NUM_SETS*CMDS | Per-slot pending bits, bit set*CMDS+slot |
| slot_addr_i | input | NUM_SETS*CMDS*ADDR_W | Stored slot addresses, same ordering |
| release_i | input | NUM_SETS | One-cycle release of claimed sets |
| done_o | output | 1 | Result valid pulse |
| busy_o | output | 1 | Request refused (collision or no free set) |
| grant_o | output | 1 | Request granted |
| grant_idx_o | output | clog2(NUM_SETS) | Granted set index |
| in_use_o | output | NUM_SETS | Claimed-set bitmap |

## Verification
The bench builds the block with four sets of four slots, four request entries and 8-bit addresses. With these values a full scan takes only sixteen cycles, so thousands of scans fit in a short run. The random address pool is small enough that collisions, early exits, exhausted groups and releases that coincide with grants all occur often. Directed cases pin down the exact latency of the early exit and the full scan, the effect of the enable bit and the valid count, and the zero-size group. After those, a randomized phase compares every output against a behavioural model on every clock.

// File: rtl/conflict_claim_pkg.sv
package conflict_claim_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cc_slot_mux.sv
module cc_slot_mux #(
  parameter int NUM_SETS = 4,
  parameter int CMDS     = 16,
  parameter int ADDR_W   = 16,
  parameter int SET_W    = 2,
  parameter int SLOT_W   = 4
) (
  input  logic [NUM_SETS*CMDS-1:0]        en_i,
  input  logic [NUM_SETS*CMDS*ADDR_W-1:0] addr_i,
  input  logic [SET_W-1:0]                set_i,
  input  logic [SLOT_W-1:0]               slot_i,
  output logic                            en_o,
  output logic [ADDR_W-1:0]               addr_o
);
  localparam int NSLOT  = NUM_SETS * CMDS;
  localparam int FLAT_W = conflict_claim_pkg::width_of(NSLOT) + 1;

  logic [ADDR_W-1:0] addr_arr [NSLOT];
  logic [FLAT_W-1:0] flat;

  for (genvar k = 0; k < NSLOT; k++) begin : g_split
    assign addr_arr[k] = addr_i[k*ADDR_W +: ADDR_W];
  end

  assign flat   = FLAT_W'(set_i) * FLAT_W'(CMDS) + FLAT_W'(slot_i);
  assign en_o   = en_i[flat];
  assign addr_o = addr_arr[flat];
endmodule

// File: rtl/cc_addr_match.sv
module cc_addr_match #(
  parameter int REQ_MAX = 16,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 5
) (
  input  logic [REQ_MAX*ADDR_W-1:0] req_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic                      match_o
);
  logic [REQ_MAX-1:0] hit_v;

  for (genvar j = 0; j < REQ_MAX; j++) begin : g_cmp
    assign hit_v[j] = (CNT_W'(j) < cnt_i) && (req_i[j*ADDR_W +: ADDR_W] == addr_i);
  end

  assign match_o = |hit_v;
endmodule

// File: rtl/cc_first_free.sv
module cc_first_free #(
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 2,
  parameter int GCNT_W   = 3
) (
  input  logic [NUM_SETS-1:0] in_use_i,
  input  logic [SET_W-1:0]    base_i,
  input  logic [GCNT_W-1:0]   cnt_i,
  output logic                found_o,
  output logic [SET_W-1:0]    idx_o
);
  // descending walk so the lowest qualifying index is written last
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SETS - 1; i >= 0; i--) begin
      if (i >= int'(base_i) && i < int'(base_i) + int'(cnt_i) && !in_use_i[i]) begin
        found_o = 1'b1;
        idx_o   = SET_W'(i);
      end
    end
  end
endmodule

// File: rtl/conflict_claim.sv
module conflict_claim
  import conflict_claim_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int CMDS     = 16,
  parameter int REQ_MAX  = 16,
  parameter int ADDR_W   = 16,
  localparam int SET_W   = width_of(NUM_SETS),
  localparam int SLOT_W  = width_of(CMDS),
  localparam int CNT_W   = $clog2(REQ_MAX + 1),
  localparam int GCNT_W  = $clog2(NUM_SETS + 1),
  localparam int NSLOT   = NUM_SETS * CMDS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [REQ_MAX*ADDR_W-1:0]  req_addr_i,
  input  logic [CNT_W-1:0]           req_cnt_i,
  input  logic [SET_W-1:0]           grp_base_i,
  input  logic [GCNT_W-1:0]          grp_cnt_i,
  input  logic [NSLOT-1:0]           slot_en_i,
  input  logic [NSLOT*ADDR_W-1:0]    slot_addr_i,
  input  logic [NUM_SETS-1:0]        release_i,
  output logic                       done_o,
  output logic                       busy_o,
  output logic                       grant_o,
  output logic [SET_W-1:0]           grant_idx_o,
  output logic [NUM_SETS-1:0]        in_use_o
);

  scan_st_e                  state_q;
  logic [SET_W-1:0]          set_q, base_q, last_set_q;
  logic [SLOT_W-1:0]         slot_q;
  logic [GCNT_W-1:0]         gcnt_q;
  logic [REQ_MAX*ADDR_W-1:0] req_q;
  logic [CNT_W-1:0]          rcnt_q;
  logic [NUM_SETS-1:0]       in_use_q;
  logic                      done_q, busy_q, grant_q;
  logic [SET_W-1:0]          gidx_q;

  logic                      cur_en, match, hit, scan_last, found, win;
  logic [ADDR_W-1:0]         cur_addr;
  logic [SET_W-1:0]          free_idx;
  logic [NUM_SETS-1:0]       grant_mask;
  logic [SET_W-1:0]          last_set_d;

  cc_slot_mux #(
    .NUM_SETS(NUM_SETS), .CMDS(CMDS), .ADDR_W(ADDR_W),
    .SET_W(SET_W), .SLOT_W(SLOT_W)
  ) u_mux (
    .en_i(slot_en_i), .addr_i(slot_addr_i),
    .set_i(set_q), .slot_i(slot_q),
    .en_o(cur_en), .addr_o(cur_addr)
  );

  cc_addr_match #(
    .REQ_MAX(REQ_MAX), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_match (
    .req_i(req_q), .cnt_i(rcnt_q), .addr_i(cur_addr), .match_o(match)
  );

  cc_first_free #(
    .NUM_SETS(NUM_SETS), .SET_W(SET_W), .GCNT_W(GCNT_W)
  ) u_free (
    .in_use_i(in_use_q), .base_i(base_q), .cnt_i(gcnt_q),
    .found_o(found), .idx_o(free_idx)
  );

  assign last_set_d = SET_W'(int'(grp_base_i) + int'(grp_cnt_i) - 1);
  assign hit        = (state_q == ST_SCAN) && in_use_q[set_q] && cur_en && match;
  assign scan_last  = (slot_q == SLOT_W'(CMDS - 1)) && (set_q == last_set_q);
  assign win        = (state_q == ST_SCAN) && !hit && scan_last && found;
  assign grant_mask = win ? (NUM_SETS'(1) << free_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      set_q      <= '0;
      slot_q     <= '0;
      base_q     <= '0;
      last_set_q <= '0;
      gcnt_q     <= '0;
      req_q      <= '0;
      rcnt_q     <= '0;
      in_use_q   <= '0;
      done_q     <= 1'b0;
      busy_q     <= 1'b0;
      grant_q    <= 1'b0;
      gidx_q     <= '0;
    end else begin
      done_q   <= 1'b0;
      busy_q   <= 1'b0;
      grant_q  <= 1'b0;
      // grant wins over a release of the same set
      in_use_q <= (in_use_q & ~release_i) | grant_mask;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (grp_cnt_i == '0) begin
              done_q <= 1'b1;
              busy_q <= 1'b1;
            end else begin
              state_q    <= ST_SCAN;
              set_q      <= grp_base_i;
              slot_q     <= '0;
              base_q     <= grp_base_i;
              last_set_q <= last_set_d;
              gcnt_q     <= grp_cnt_i;
              req_q      <= req_addr_i;
              rcnt_q     <= req_cnt_i;
            end
          end
        end
        ST_SCAN: begin
          if (hit) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            busy_q  <= 1'b1;
          end else if (scan_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            busy_q  <= !found;
            grant_q <= found;
            if (found) gidx_q <= free_idx;
          end else if (slot_q == SLOT_W'(CMDS - 1)) begin
            slot_q <= '0;
            set_q  <= set_q + SET_W'(1);
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign busy_o      = busy_q;
  assign grant_o     = grant_q;
  assign grant_idx_o = gidx_q;
  assign in_use_o    = in_use_q;

  p_result_needs_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || grant_o) |-> done_o);

  p_single_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o ^ grant_o));

  p_hit_refuses_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (done_o && busy_o && !grant_o));

  p_grant_claims_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> ((in_use_q & ~$past(in_use_q)) == (NUM_SETS'(1) << grant_idx_o)));

  p_grant_in_group_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (int'(grant_idx_o) >= int'(base_q) &&
                 int'(grant_idx_o) < int'(base_q) + int'(gcnt_q)));

  p_release_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i != '0) |=> ((in_use_q & $past(release_i) & ~(grant_o ? (NUM_SETS'(1) << grant_idx_o) : '0)) == '0));

  p_req_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && $past(state_q == ST_SCAN)) |-> ($stable(rcnt_q) && $stable(base_q)));

endmodule

// File: tb/tb_conflict_claim.sv
`timescale 1ns/1ps
module tb_conflict_claim;
  localparam int NS    = 4;
  localparam int CM    = 4;
  localparam int RQ    = 4;
  localparam int AW    = 8;
  localparam int SW    = 2;
  localparam int CW    = 3;
  localparam int GW    = 3;
  localparam int NSLOT = NS * CM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              start = 1'b0;
  logic [AW-1:0]     r_addr [RQ];
  logic [CW-1:0]     r_cnt = '0;
  logic [SW-1:0]     g_base = '0;
  logic [GW-1:0]     g_cnt = '0;
  logic [NSLOT-1:0]  s_en = '0;
  logic [AW-1:0]     s_addr [NSLOT];
  logic [NS-1:0]     rel = '0;

  logic [RQ*AW-1:0]    req_flat;
  logic [NSLOT*AW-1:0] slot_flat;
  always_comb begin
    for (int j = 0; j < RQ; j++) req_flat[j*AW +: AW] = r_addr[j];
    for (int k = 0; k < NSLOT; k++) slot_flat[k*AW +: AW] = s_addr[k];
  end

  logic          done_o, busy_o, grant_o;
  logic [SW-1:0] gidx_o;
  logic [NS-1:0] use_o;

  conflict_claim #(.NUM_SETS(NS), .CMDS(CM), .REQ_MAX(RQ), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .req_addr_i(req_flat), .req_cnt_i(r_cnt),
    .grp_base_i(g_base), .grp_cnt_i(g_cnt),
    .slot_en_i(s_en), .slot_addr_i(slot_flat), .release_i(rel),
    .done_o(done_o), .busy_o(busy_o), .grant_o(grant_o),
    .grant_idx_o(gidx_o), .in_use_o(use_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int          m_st, m_set, m_slot, m_base, m_cnt, m_rc;
  logic [AW-1:0] m_req [RQ];
  logic [NS-1:0] m_use;
  logic        e_done, e_busy, e_grant;
  int          e_idx;

  task automatic model_step();
    logic [NS-1:0] gm;
    logic hit;
    logic fnd;
    gm = '0;
    if (!rst_n) begin
      m_st = 0; m_use = '0; e_done = 0; e_busy = 0; e_grant = 0; e_idx = 0;
      return;
    end
    e_done = 0; e_busy = 0; e_grant = 0;
    if (m_st == 0) begin
      if (start) begin
        if (g_cnt == 0) begin
          e_done = 1; e_busy = 1;
        end else begin
          m_st = 1; m_base = int'(g_base); m_cnt = int'(g_cnt); m_rc = int'(r_cnt);
          for (int j = 0; j < RQ; j++) m_req[j] = r_addr[j];
          m_set = m_base; m_slot = 0;
        end
      end
    end else begin
      hit = 0;
      if (m_use[m_set] && s_en[m_set*CM + m_slot])
        for (int j = 0; j < m_rc; j++)
          if (m_req[j] == s_addr[m_set*CM + m_slot]) hit = 1;
      if (hit) begin
        e_done = 1; e_busy = 1; m_st = 0;
      end else if (m_slot == CM - 1 && m_set == m_base + m_cnt - 1) begin
        fnd = 0;
        for (int i = m_base; i < m_base + m_cnt; i++)
          if (!fnd && !m_use[i]) begin fnd = 1; e_idx = i; end
        e_done = 1;
        if (fnd) begin e_grant = 1; gm[e_idx] = 1'b1; end
        else e_busy = 1;
        m_st = 0;
      end else if (m_slot == CM - 1) begin
        m_slot = 0; m_set++;
      end else begin
        m_slot++;
      end
    end
    m_use = (m_use & ~rel) | gm;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    chk("R2 model", {e_done, e_busy, e_grant, (e_grant ? 2'(e_idx) : 2'b0), m_use},
        {done_o, busy_o, grant_o, (grant_o ? gidx_o : 2'b0), use_o});
    @(negedge clk);
  endtask

  task automatic launch(input int base, input int cnt, input int rc);
    g_base = SW'(base); g_cnt = GW'(cnt); r_cnt = CW'(rc);
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 200) begin tick(); n++; end
  endtask

  int lat;
  bit wd_hit = 0;

  initial begin
    #(200000 * 5);
    wd_hit = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < RQ; j++) r_addr[j] = '0;
    for (int k = 0; k < NSLOT; k++) s_addr[k] = AW'(8'h10 + k);
    s_en = '1;
    @(negedge clk);
    tick(); tick();
    // R1 reset state
    chk("R1 in_use", use_o, 0);
    chk("R1 done", {done_o, busy_o, grant_o}, 0);
    rst_n = 1'b1;
    tick();

    // R3: set 0 holds a matching address but is unclaimed -> skipped
    r_addr[0] = 8'h10; r_addr[1] = 8'h12;
    launch(0, 4, 2);
    wait_done(lat);
    chk("R2 full latency", lat, 16);
    chk("R3 unclaimed skipped grant", grant_o, 1);
    chk("R6 lowest free idx", gidx_o, 0);
    chk("R6 in_use same edge", use_o, 4'b0001);

    // R5: collision in set 0 slot 2 ends scan early
    r_addr[0] = 8'h77; r_addr[1] = 8'h12;
    launch(0, 4, 2);
    wait_done(lat);
    chk("R5 early latency", lat, 3);
    chk("R5 busy", {busy_o, grant_o}, 2'b10);
    chk("R5 in_use unchanged", use_o, 4'b0001);

    // R3: disabled slot does not collide
    s_en[2] = 1'b0;
    launch(0, 4, 2);
    wait_done(lat);
    chk("R3 disabled slot grant", {grant_o, gidx_o}, {1'b1, 2'd1});
    chk("R3 in_use", use_o, 4'b0011);
    s_en[2] = 1'b1;

    // R4: matching entry beyond count is ignored
    launch(0, 4, 1);
    wait_done(lat);
    chk("R4 beyond count grant", {grant_o, gidx_o}, {1'b1, 2'd2});

    // R10 release, R6 window lowest free
    rel = 4'b0010;
    tick();
    rel = '0;
    chk("R10 release clears", use_o, 4'b0101);
    launch(1, 3, 0);
    wait_done(lat);
    chk("R2 three-set latency", lat, 12);
    chk("R6 window grant", {grant_o, gidx_o}, {1'b1, 2'd1});

    // R7 all of group claimed
    launch(0, 3, 0);
    wait_done(lat);
    chk("R7 exhausted busy", {done_o, busy_o, grant_o}, 3'b110);

    // R8 zero-size group
    launch(2, 0, 0);
    chk("R8 zero group done", {done_o, busy_o, grant_o}, 3'b110);
    tick();
    chk("R8 single pulse", done_o, 0);

    // R9 start during scan ignored
    launch(3, 1, 0);
    tick(); tick();
    g_cnt = '0; start = 1'b1;
    tick();
    start = 1'b0;
    chk("R9 no early done", done_o, 0);
    tick();
    chk("R9 scan completes", {done_o, grant_o, gidx_o}, {2'b11, 2'd3});
    tick();
    chk("R9 no extra done", done_o, 0);

    // R10 release coinciding with grant of same set
    rel = 4'b1000;
    tick();
    rel = '0;
    launch(3, 1, 0);
    tick(); tick(); tick();
    rel = 4'b1000;
    tick();
    rel = '0;
    chk("R10 grant wins", {grant_o, use_o[3]}, 2'b11);

    // randomized phase (R11 and all others via model)
    for (int c = 0; c < 4000; c++) begin
      int b;
      start = ($urandom_range(0, 3) == 0);
      b = $urandom_range(0, NS - 1);
      g_base = SW'(b);
      g_cnt = GW'($urandom_range(0, NS - b));
      r_cnt = CW'($urandom_range(0, RQ));
      for (int j = 0; j < RQ; j++) r_addr[j] = AW'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0)
        for (int k = 0; k < NSLOT; k++) begin
          s_addr[k] = AW'($urandom_range(0, 7));
          s_en[k] = ($urandom_range(0, 2) != 0);
        end
      rel = ($urandom_range(0, 5) == 0) ? NS'($urandom_range(0, 15)) : '0;
      tick();
      if (done_o) chk("R11 one result", {1'b0, busy_o ^ grant_o}, 2'b01);
    end
    start = 1'b0; rel = '0;
    tick();

    if (!wd_hit) begin
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule